// File: doc/BRIEF.md
# Boundary Scan Data Register Chain

This block is the boundary scan data register of a device with a configurable number of I/O blocks. Every I/O block contributes three scan cells: one watching the pad input, one for the pad output value and one for the pad output enable. Three fixed cells sit outside the pin groups. The two lowest positions hold the serial-output enable and data. The highest position holds an update marker that belongs to no pin. The configuration-control pins (program, configuration clock, done) have no cells.

A TAP controller outside this block drives the capture, shift and update strobes. It also drives a select that is high while the current instruction (EXTEST or SAMPLE) routes scans through this register, and a separate EXTEST flag. The chain loads pin-side values on a capture and moves one bit per rising TCK while shifting. Each cell has a shadow latch that takes the shift stage on the falling TCK edge of an update. While EXTEST is active, the pads are driven from those latches instead of from core logic.

Top module: `bscan_chain`

## Requirements
- R1: The chain holds 3*N_IOB+3 cells. While `sel_chain` and `shift_dr` are high and `capture_dr` is low, each rising `tck` moves every cell one position toward bit 0 and loads `tdi` into the highest cell. `tdo` always shows bit 0.
- R2: The cell layout is as follows. Bit 0 is the serial-output enable cell and bit 1 is the serial-output data cell. I/O block i uses bit 2+3i for its input cell, bit 3+3i for its output cell and bit 4+3i for its enable cell. Bit 3*N_IOB+2 is the update marker.
- R3: A rising `tck` with `sel_chain` and `capture_dr` high loads every cell in one edge. Bit 0 takes `tdo_oe_in` and bit 1 takes `tdo_dat_in`. Input cells take `pad_in`, output cells take the driven `pad_out`, enable cells take the driven `pad_oe`, and the marker takes 0. Capture takes priority over shift.
- R4: On a falling `tck` with `sel_chain` and `update_dr` high, every shadow latch loads its shift-stage cell. At any other falling edge the latches hold their values.
- R5: With `extest` high, `pad_out[i]` and `pad_oe[i]` are the latches of cells 3+3i and 4+3i. With `extest` low, they equal `core_out[i]` and `core_oe[i]`.
- R6: While `sel_chain` is low, the capture, shift and update strobes change neither the shift stage nor the latches.
- R7: A low `trst_n` clears the shift stage and all latches at once, without waiting for a clock edge.
- R8: `upd_tdo_oe`, `upd_tdo_dat` and `upd_marker` present the latches of cells 0, 1 and 3*N_IOB+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| sel_chain | input | 1 | Current instruction selects this register |
| extest | input | 1 | EXTEST active: pads driven from latches |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| update_dr | input | 1 | Update-DR state strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (cell 0) |
| tdo_oe_in | input | 1 | Observed serial-output enable, captured into cell 0 |
| tdo_dat_in | input | 1 | Observed serial-output data, captured into cell 1 |
| pad_in | input | N_IOB | Pad input values |
| core_out | input | N_IOB | Core output values |
| core_oe | input | N_IOB | Core output enables |
| pad_out | output | N_IOB | Output value driven to pads |
| pad_oe | output | N_IOB | Output enable driven to pads |
| upd_tdo_oe | output | 1 | Latch of cell 0 |
| upd_tdo_dat | output | 1 | Latch of cell 1 |
| upd_marker | output | 1 | Latch of the marker cell |

## Verification
The bench builds the block with N_IOB = 4, which gives a 15-cell chain. At that size every cell kind appears several times, so the bench can check the position of each field on a full serial round trip. Two captures are run, one under SAMPLE and one under EXTEST, so the output and enable cells are shown taking core values in one case and latch values in the other. Strobes issued while deselected, shifting that ends without an update, and a reset applied under EXTEST are each followed by a check at the pads and at `tdo`.

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N_IOB = 4
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             sel_chain,
  input  logic             extest,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  output logic             tdo,
  input  logic             tdo_oe_in,
  input  logic             tdo_dat_in,
  input  logic [N_IOB-1:0] pad_in,
  input  logic [N_IOB-1:0] core_out,
  input  logic [N_IOB-1:0] core_oe,
  output logic [N_IOB-1:0] pad_out,
  output logic [N_IOB-1:0] pad_oe,
  output logic             upd_tdo_oe,
  output logic             upd_tdo_dat,
  output logic             upd_marker
);
  localparam int LEN  = 3*N_IOB + 3;
  localparam int MARK = LEN - 1;

  logic [LEN-1:0]   sr, cap;
  logic [N_IOB-1:0] lat_out, lat_oe;
  logic [1:0]       lat_tdo;
  logic             lat_mark;

  always_comb begin
    cap       = '0;
    cap[0]    = tdo_oe_in;
    cap[1]    = tdo_dat_in;
    for (int i = 0; i < N_IOB; i++) begin
      cap[2+3*i] = pad_in[i];
      cap[3+3*i] = pad_out[i];
      cap[4+3*i] = pad_oe[i];
    end
    cap[MARK] = 1'b0;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)
      sr <= '0;
    else if (sel_chain && capture_dr)
      sr <= cap;
    else if (sel_chain && shift_dr)
      sr <= {tdi, sr[LEN-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      lat_out  <= '0;
      lat_oe   <= '0;
      lat_tdo  <= '0;
      lat_mark <= 1'b0;
    end else if (sel_chain && update_dr) begin
      for (int i = 0; i < N_IOB; i++) begin
        lat_out[i] <= sr[3+3*i];
        lat_oe[i]  <= sr[4+3*i];
      end
      lat_tdo  <= sr[1:0];
      lat_mark <= sr[MARK];
    end
  end

  generate
    for (genvar g = 0; g < N_IOB; g++) begin : g_pad
      assign pad_out[g] = extest ? lat_out[g] : core_out[g];
      assign pad_oe[g]  = extest ? lat_oe[g]  : core_oe[g];
    end
  endgenerate

  assign tdo         = sr[0];
  assign upd_tdo_oe  = lat_tdo[0];
  assign upd_tdo_dat = lat_tdo[1];
  assign upd_marker  = lat_mark;
endmodule

module bscan_chain_chk #(
  parameter int N_IOB = 4
) (
  input logic                 tck,
  input logic                 trst_n,
  input logic                 sel_chain,
  input logic                 extest,
  input logic                 capture_dr,
  input logic                 shift_dr,
  input logic                 update_dr,
  input logic                 tdi,
  input logic                 tdo_oe_in,
  input logic                 tdo_dat_in,
  input logic [N_IOB-1:0]     pad_in,
  input logic [N_IOB-1:0]     core_out,
  input logic [N_IOB-1:0]     core_oe,
  input logic [N_IOB-1:0]     pad_out,
  input logic [N_IOB-1:0]     pad_oe,
  input logic [3*N_IOB+2:0]   sr,
  input logic [N_IOB-1:0]     lat_out,
  input logic [N_IOB-1:0]     lat_oe
);
  localparam int LEN = 3*N_IOB + 3;

  // R1
  shift_move_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (sel_chain && shift_dr && !capture_dr) |=>
      (sr[LEN-1] == $past(tdi)) && (sr[LEN-2:0] == $past(sr[LEN-1:1])));

  // R3
  capture_load_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (sel_chain && capture_dr) |=>
      (sr[0] == $past(tdo_oe_in)) && (sr[1] == $past(tdo_dat_in)) &&
      (sr[2] == $past(pad_in[0])) && (sr[LEN-1] == 1'b0));

  // R4
  latch_hold_chk: assert property (@(negedge tck) disable iff (!trst_n)
    !(sel_chain && update_dr) |=> ($stable(lat_out) && $stable(lat_oe)));

  // R5
  core_path_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !extest |-> (pad_out == core_out) && (pad_oe == core_oe));

  // R5
  test_path_chk: assert property (@(posedge tck) disable iff (!trst_n)
    extest |-> (pad_out == lat_out) && (pad_oe == lat_oe));

  // R6
  deselect_idle_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !sel_chain |=> $stable(sr));
endmodule

bind bscan_chain bscan_chain_chk #(.N_IOB(N_IOB)) u_chk (
  .tck(tck), .trst_n(trst_n), .sel_chain(sel_chain), .extest(extest),
  .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
  .tdi(tdi), .tdo_oe_in(tdo_oe_in), .tdo_dat_in(tdo_dat_in),
  .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
  .pad_out(pad_out), .pad_oe(pad_oe), .sr(sr),
  .lat_out(lat_out), .lat_oe(lat_oe)
);

// File: tb/bscan_chain_test.sv
module bscan_chain_test;
  localparam int N = 4;
  localparam int L = 3*N + 3;

  logic tck = 1'b0;
  always #2 tck = ~tck;

  logic trst_n = 1'b0, sel_chain = 1'b0, extest = 1'b0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic tdo_oe_in = 1'b0, tdo_dat_in = 1'b0;
  logic [N-1:0] pad_in = '0, core_out = '0, core_oe = '0;
  logic tdo, upd_tdo_oe, upd_tdo_dat, upd_marker;
  logic [N-1:0] pad_out, pad_oe;

  bscan_chain #(.N_IOB(N)) uut (
    .tck(tck), .trst_n(trst_n), .sel_chain(sel_chain), .extest(extest),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo), .tdo_oe_in(tdo_oe_in), .tdo_dat_in(tdo_dat_in),
    .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .upd_tdo_oe(upd_tdo_oe),
    .upd_tdo_dat(upd_tdo_dat), .upd_marker(upd_marker)
  );

  int runs = 0, fails = 0;
  bit    exp_q[$];
  string tag_q[$];
  logic [N-1:0] m_out = '0, m_oe = '0;
  logic [1:0]   m_tdo = '0;
  logic         m_mark = 1'b0;

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge tck)
    if (sel_chain && shift_dr && !capture_dr && exp_q.size() > 0)
      check(tag_q.pop_front(), {31'd0, tdo}, {31'd0, exp_q.pop_front()});

  task automatic step();
    @(posedge tck); #1;
  endtask

  function automatic logic [L-1:0] cap_model();
    logic [L-1:0] v = '0;
    v[0] = tdo_oe_in;
    v[1] = tdo_dat_in;
    for (int i = 0; i < N; i++) begin
      v[2+3*i] = pad_in[i];
      v[3+3*i] = extest ? m_out[i] : core_out[i];
      v[4+3*i] = extest ? m_oe[i]  : core_oe[i];
    end
    v[L-1] = 1'b0;
    return v;
  endfunction

  task automatic do_capture();
    capture_dr = 1'b1; step(); capture_dr = 1'b0;
  endtask

  task automatic shift_pat(input logic [L-1:0] p, input logic [L-1:0] e, input string r);
    for (int k = 0; k < L; k++) begin
      shift_dr = 1'b1; tdi = p[k];
      exp_q.push_back(e[k]); tag_q.push_back(r);
      step();
    end
    shift_dr = 1'b0;
  endtask

  task automatic do_update(input logic [L-1:0] p);
    update_dr = 1'b1; step(); update_dr = 1'b0;
    for (int i = 0; i < N; i++) begin
      m_out[i] = p[3+3*i];
      m_oe[i]  = p[4+3*i];
    end
    m_tdo  = p[1:0];
    m_mark = p[L-1];
  endtask

  task automatic check_pads(input string r);
    check(r, {28'd0, pad_out}, {28'd0, extest ? m_out : core_out});
    check(r, {28'd0, pad_oe},  {28'd0, extest ? m_oe  : core_oe});
  endtask

  task automatic check_upd(input string r);
    check(r, {29'd0, upd_marker, upd_tdo_dat, upd_tdo_oe}, {29'd0, m_mark, m_tdo[1], m_tdo[0]});
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [L-1:0] p, q;
    core_out = 4'hA; core_oe = 4'h6;
    step(); step();
    // R7: state right after reset
    check("R7", {31'd0, tdo}, 32'd0);
    check_pads("R7");
    check_upd("R7");
    trst_n = 1'b1; step();

    // SAMPLE capture, full round trip (R1, R2, R3)
    pad_in = 4'h5; core_out = 4'h9; core_oe = 4'h3;
    tdo_oe_in = 1'b1; tdo_dat_in = 1'b0; sel_chain = 1'b1;
    do_capture();
    p = 15'h4D2B;
    shift_pat(p, cap_model(), "R2 R3 sample capture");
    do_update(p);
    check_upd("R8");
    check_pads("R5 core path");
    extest = 1'b1; #1;
    check_pads("R5 test path");

    // EXTEST capture sees latch-driven pads
    core_out = 4'h6; core_oe = 4'hC; pad_in = 4'hA;
    tdo_oe_in = 1'b0; tdo_dat_in = 1'b1; #1;
    check_pads("R5 core ignored");
    do_capture();
    q = 15'h3A5C;
    shift_pat(q, cap_model(), "R1 R3 extest capture");
    check_pads("R4 hold while shifting");
    do_update(q);
    check_pads("R4 update");
    check_upd("R8");

    // Deselected strobes
    sel_chain = 1'b0; tdi = 1'b1;
    capture_dr = 1'b1; shift_dr = 1'b1; update_dr = 1'b1;
    step(); step(); step();
    capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
    check_pads("R6 latches");
    check_upd("R6");
    sel_chain = 1'b1;
    shift_pat('0, q, "R6 shift stage");
    check_pads("R4 hold");

    // Asynchronous reset under EXTEST
    #1 trst_n = 1'b0; #1;
    m_out = '0; m_oe = '0; m_tdo = '0; m_mark = 1'b0;
    check_pads("R7");
    check_upd("R7");
    check("R7", {31'd0, tdo}, 32'd0);
    trst_n = 1'b1; step();

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule